// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Datapath

This block is a 32-bit in-order execution pipeline for a small load/store instruction subset. It runs seven operations: word load, word store, register add, subtract, bitwise AND, bitwise OR, and branch-on-equal. Work is split across fetch, decode, execute, memory access and writeback. A bank of registers between each pair of neighbouring stages carries every value and control bit a later stage needs. The instruction store and the data store are small word-addressed arrays inside the block. The next sequential address has its own adder, the branch destination has a second adder, and a single ALU does the execute work.

There is no hazard logic. Programs must be placed so that a consumer reads a register no earlier than the cycle in which its producer writes it back. The same rule applies to code behind a branch. A debug view shows the fetch address and the writeback port, which is the only way results can be seen. Every pipeline register and the fetch address are loaded on every clock edge, and the block has no enables.

Top module: `pipe5_core`

## Requirements
- R1: When the synchronous active-high reset is applied, the fetch address becomes 0 and every pipeline register becomes a bubble, so the writeback port is idle. Register k (k>0) is set to k+RF_BASE (100 by default), register 0 reads as 0, and every data word is set to DMEM_FILL (99 by default).
- R2: When no branch is taken, the fetch address grows by 4 on every clock edge with no stall.
- R3: The first cycle after reset is cycle 0. An instruction fetched in cycle n reaches the writeback port in cycle n+4, and one instruction retires per cycle after that. A five-instruction run therefore retires its last result in the ninth cycle.
- R4: Opcode 0 (bits 31-26) is a register operation. The function field in bits 5-0 picks the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. Sources come from bits 25-21 and 20-16, and the destination is bits 15-11.
- R5: Opcode 0x23 loads the data word at source(25-21) + sign-extended bits 15-0 into the register named by bits 20-16. The word index is the address bits above bit 1.
- R6: Opcode 0x2B stores the register named by bits 20-16 at the same kind of address and never drives the writeback port. A load that reaches the memory stage on the next cycle sees the stored value.
- R7: Opcode 0x04 compares its two source registers. If they are equal, the fetch address in cycle n+4 is (branch address + 4) + (sign-extended bits 15-0 shifted left by 2), where n is the branch's fetch cycle. If they differ, the branch has no effect.
- R8: The three instructions fetched behind a taken branch still complete and write back.
- R9: A value that is being written back can be read by the instruction in decode in that same cycle. An instruction that decodes one cycle earlier sees the old value.
- R10: Register 0 always reads as zero. A write to register 0 is dropped and does not assert the writeback-valid output.
- R11: Any other opcode, or an opcode 0 with another function code, acts as a bubble: it causes no writeback and no data-store write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Current fetch address |
| dbg_wb_en | output | 1 | A register write happens this cycle |
| dbg_wb_reg | output | 5 | Register being written back |
| dbg_wb_data | output | 32 | Value being written back |

## Verification
Results leave the block only through the writeback port. A corrupted field in a pipeline register therefore shows up as a wrong register number, wrong data or a wrong valid flag, exactly four cycles after the fetch of the affected instruction. A wrong branch decision shows up on the fetch address at once: the first address after the branch's memory-stage cycle is wrong. The dropped instructions then appear on the writeback port four cycles after that. Errors in the same-cycle register bypass and in the store path can only be seen one or two instructions later, through the values a dependent instruction writes back. For that reason the programs are arranged so that those dependents retire in known cycles.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    // Opcode and function codes (positions and values are decoded behaviour)
    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_SUB    = 6'h22;
    localparam logic [5:0] FN_AND    = 6'h24;
    localparam logic [5:0] FN_OR     = 6'h25;

    // Control, grouped by the stage that consumes it
    typedef struct packed {
        logic    use_imm;   // ALU operand B from the immediate
        logic    dst_rd;    // destination from bits 15-11
        alu_op_e op;
    } ex_ctl_t;

    typedef struct packed {
        logic store;
        logic branch;
    } mem_ctl_t;

    typedef struct packed {
        logic wr_en;
        logic from_mem;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_t;

    typedef struct packed {
        word_t pc4;
        word_t instr;
    } ifid_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
        word_t    pc4;
        word_t    rs_val;
        word_t    rt_val;
        word_t    imm;
        ridx_t    rt;
        ridx_t    rd;
    } idex_t;

    typedef struct packed {
        mem_ctl_t mem;
        wb_ctl_t  wb;
        word_t    br_tgt;
        logic     zero;
        word_t    alu_y;
        word_t    st_data;
        ridx_t    dst;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t wb;
        word_t   ld_data;
        word_t   alu_y;
        ridx_t   dst;
    } memwb_t;

    typedef struct packed {
        word_t  pc;
        ifid_t  ifid;
        idex_t  idex;
        exmem_t exmem;
        memwb_t memwb;
    } pipe_t;

    function automatic ctl_t decode(input logic [5:0] opc, input logic [5:0] fn);
        ctl_t c;
        c = '0;
        unique case (opc)
            OPC_REG: begin
                c.ex.dst_rd = 1'b1;
                c.wb.wr_en  = 1'b1;
                case (fn)
                    FN_ADD:  c.ex.op = ALU_ADD;
                    FN_SUB:  c.ex.op = ALU_SUB;
                    FN_AND:  c.ex.op = ALU_AND;
                    FN_OR:   c.ex.op = ALU_OR;
                    default: c = '0;
                endcase
            end
            OPC_LOAD: begin
                c.ex.use_imm   = 1'b1;
                c.wb.wr_en     = 1'b1;
                c.wb.from_mem  = 1'b1;
            end
            OPC_STORE: begin
                c.ex.use_imm   = 1'b1;
                c.mem.store    = 1'b1;
            end
            OPC_BEQ: begin
                c.ex.op        = ALU_SUB;
                c.mem.branch   = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/p5_alu.sv
module p5_alu
    import pipe5_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_op_e op,
    output word_t   y,
    output logic    zero
);

    always_comb begin
        y = '0;
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/p5_regfile.sv
module p5_regfile
    import pipe5_pkg::*;
#(
    parameter int BASE = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t raddr_a,
    input  ridx_t raddr_b,
    output word_t rdata_a,
    output word_t rdata_b
);

    localparam int NREG = 1 << RIDX;

    word_t regs_q [NREG];
    logic  wr_live;

    assign wr_live = we && (waddr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= (i == 0) ? '0 : word_t'(i + BASE);
            end
        end else if (wr_live) begin
            regs_q[waddr] <= wdata;
        end
    end

    // Write lands early in the cycle: a same-cycle reader sees the new value
    always_comb begin
        if (raddr_a == '0)                      rdata_a = '0;
        else if (wr_live && waddr == raddr_a)   rdata_a = wdata;
        else                                    rdata_a = regs_q[raddr_a];

        if (raddr_b == '0)                      rdata_b = '0;
        else if (wr_live && waddr == raddr_b)   rdata_b = wdata;
        else                                    rdata_b = regs_q[raddr_b];
    end

endmodule

// File: rtl/p5_imem.sv
module p5_imem
    import pipe5_pkg::*;
#(
    parameter  int WORDS = 64,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic [AW-1:0] idx,
    output word_t         instr
);

    word_t rom [WORDS];

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            rom[i] = '0;
        end
    end

    assign instr = rom[idx];

endmodule

// File: rtl/p5_dmem.sv
module p5_dmem
    import pipe5_pkg::*;
#(
    parameter  int WORDS = 64,
    parameter  int FILL  = 99,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  word_t         wdata,
    output word_t         rdata
);

    word_t mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= word_t'(FILL);
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int RF_BASE    = 100,
    parameter int DMEM_FILL  = 99
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] dbg_pc,
    output logic        dbg_wb_en,
    output logic [4:0]  dbg_wb_reg,
    output logic [31:0] dbg_wb_data
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    pipe_t st_q, st_d;

    word_t if_instr;
    word_t pc_plus4;
    word_t rf_rd_a, rf_rd_b;
    word_t alu_b, alu_y;
    logic  alu_zero;
    word_t dm_rdata;
    word_t wb_data;
    word_t br_target;
    logic  br_take;
    logic  dm_we;
    ctl_t  id_ctl;

    // ---------------- fetch ----------------
    p5_imem #(.WORDS(IMEM_WORDS)) u_imem (
        .idx   (st_q.pc[IAW+1:2]),
        .instr (if_instr)
    );

    assign pc_plus4 = st_q.pc + 32'd4;

    // ---------------- decode ----------------
    assign id_ctl = decode(st_q.ifid.instr[31:26], st_q.ifid.instr[5:0]);

    p5_regfile #(.BASE(RF_BASE)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (st_q.memwb.wb.wr_en),
        .waddr   (st_q.memwb.dst),
        .wdata   (wb_data),
        .raddr_a (st_q.ifid.instr[25:21]),
        .raddr_b (st_q.ifid.instr[20:16]),
        .rdata_a (rf_rd_a),
        .rdata_b (rf_rd_b)
    );

    // ---------------- execute ----------------
    assign alu_b = st_q.idex.ex.use_imm ? st_q.idex.imm : st_q.idex.rt_val;

    p5_alu u_alu (
        .a    (st_q.idex.rs_val),
        .b    (alu_b),
        .op   (st_q.idex.ex.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---------------- memory ----------------
    assign dm_we     = st_q.exmem.mem.store;
    assign br_take   = st_q.exmem.mem.branch & st_q.exmem.zero;
    assign br_target = st_q.exmem.br_tgt;

    p5_dmem #(.WORDS(DMEM_WORDS), .FILL(DMEM_FILL)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .idx   (st_q.exmem.alu_y[DAW+1:2]),
        .wdata (st_q.exmem.st_data),
        .rdata (dm_rdata)
    );

    // ---------------- writeback ----------------
    assign wb_data = st_q.memwb.wb.from_mem ? st_q.memwb.ld_data : st_q.memwb.alu_y;

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;

        // fetch address: sequential or resolved branch
        st_d.pc = br_take ? br_target : pc_plus4;

        // IF/ID
        st_d.ifid.pc4   = pc_plus4;
        st_d.ifid.instr = if_instr;

        // ID/EX
        st_d.idex.ex     = id_ctl.ex;
        st_d.idex.mem    = id_ctl.mem;
        st_d.idex.wb     = id_ctl.wb;
        st_d.idex.pc4    = st_q.ifid.pc4;
        st_d.idex.rs_val = rf_rd_a;
        st_d.idex.rt_val = rf_rd_b;
        st_d.idex.imm    = {{16{st_q.ifid.instr[15]}}, st_q.ifid.instr[15:0]};
        st_d.idex.rt     = st_q.ifid.instr[20:16];
        st_d.idex.rd     = st_q.ifid.instr[15:11];

        // EX/MEM
        st_d.exmem.mem     = st_q.idex.mem;
        st_d.exmem.wb      = st_q.idex.wb;
        st_d.exmem.br_tgt  = st_q.idex.pc4 + (st_q.idex.imm << 2);
        st_d.exmem.zero    = alu_zero;
        st_d.exmem.alu_y   = alu_y;
        st_d.exmem.st_data = st_q.idex.rt_val;
        st_d.exmem.dst     = st_q.idex.ex.dst_rd ? st_q.idex.rd : st_q.idex.rt;

        // MEM/WB
        st_d.memwb.wb      = st_q.exmem.wb;
        st_d.memwb.ld_data = dm_rdata;
        st_d.memwb.alu_y   = st_q.exmem.alu_y;
        st_d.memwb.dst     = st_q.exmem.dst;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // ---------------- debug view ----------------
    assign dbg_pc      = st_q.pc;
    assign dbg_wb_en   = st_q.memwb.wb.wr_en && (st_q.memwb.dst != '0);
    assign dbg_wb_reg  = st_q.memwb.dst;
    assign dbg_wb_data = wb_data;

endmodule

// File: rtl/p5_checker.sv
module p5_checker
    import pipe5_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input word_t dbg_pc,
    input logic  dbg_wb_en,
    input logic  br_take,
    input word_t br_target,
    input logic  dm_we
);

    // R1: reset leaves fetch at zero and the writeback port idle
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && !dbg_wb_en));

    // R2: sequential fetch advances by one word each cycle
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !br_take |=> dbg_pc == $past(dbg_pc) + 32'd4);

    // R7: a resolved taken branch redirects fetch on the next edge
    a_r7_branch_redirect: assert property (@(posedge clk) disable iff (rst)
        br_take |=> dbg_pc == $past(br_target));

    // R6: a store in the memory stage retires without a register write
    a_r6_store_silent: assert property (@(posedge clk) disable iff (rst)
        dm_we |=> !dbg_wb_en);

endmodule

bind pipe5_core p5_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbg_pc    (dbg_pc),
    .dbg_wb_en (dbg_wb_en),
    .br_take   (br_take),
    .br_target (br_target),
    .dm_we     (dm_we)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;
    import pipe5_pkg::*;

    localparam int IMW  = 64;
    localparam int LOGN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_wb_en;
    logic [4:0]  dbg_wb_reg;
    logic [31:0] dbg_wb_data;

    pipe5_core #(.IMEM_WORDS(IMW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .dbg_pc      (dbg_pc),
        .dbg_wb_en   (dbg_wb_en),
        .dbg_wb_reg  (dbg_wb_reg),
        .dbg_wb_data (dbg_wb_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_vec = 0;
    int n_bad = 0;

    word_t pc_log  [LOGN];
    logic  en_log  [LOGN];
    word_t reg_log [LOGN];
    word_t dat_log [LOGN];

    function automatic word_t enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic word_t enc_i(input logic [5:0] opc, input int rs, input int rt, input int imm);
        return {opc, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic chk(input string tag, input word_t act, input word_t exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_wb(input string tag, input int c, input int rg, input word_t val);
        chk({tag, " valid"}, word_t'(en_log[c]), 32'd1);
        chk({tag, " reg"},   reg_log[c], word_t'(rg));
        chk({tag, " data"},  dat_log[c], val);
    endtask

    task automatic chk_idle(input string tag, input int c);
        chk({tag, " idle"}, word_t'(en_log[c]), 32'd0);
    endtask

    // Hold reset and blank the program store
    task automatic new_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < IMW; i++) u_dut.u_imem.rom[i] = '0;
    endtask

    task automatic put(input int idx, input word_t w);
        u_dut.u_imem.rom[idx] = w;
    endtask

    // Release reset; log[0] is cycle 0 (reset state), log[c] after the c-th edge
    task automatic run(input int ncyc);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        pc_log[0] = dbg_pc; en_log[0] = dbg_wb_en;
        reg_log[0] = word_t'(dbg_wb_reg); dat_log[0] = dbg_wb_data;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            pc_log[c]  = dbg_pc;
            en_log[c]  = dbg_wb_en;
            reg_log[c] = word_t'(dbg_wb_reg);
            dat_log[c] = dbg_wb_data;
        end
    endtask

    // R1, R2, R11: reset state, free-running fetch, bubble encodings
    task automatic t_reset_and_bubbles();
        new_prog();
        put(0, enc_i(6'h2F, 0, 1, 8));          // unknown opcode shaped like a store
        put(2, enc_r(1, 2, 3, 6'h21));          // unknown function code
        put(4, enc_i(OPC_LOAD, 0, 2, 8));       // lw r2, 8(r0)
        run(10);
        chk("R1 pc after reset", pc_log[0], 32'd0);
        chk_idle("R1 wb after reset", 0);
        for (int c = 1; c <= 10; c++) chk("R2 pc step", pc_log[c], word_t'(4 * c));
        chk_idle("R11 unknown opcode", 4);
        chk_idle("R11 unknown funct", 6);
        chk_wb("R11 no store from unknown opcode", 8, 2, 32'd99);
    endtask

    // R3, R4, R5, R10: five-instruction sequence with preset registers
    task automatic t_sequence();
        new_prog();
        put(0, enc_i(OPC_LOAD, 29, 8, 4));      // lw  r8, 4(r29)
        put(1, enc_r(4, 5, 2, FN_SUB));         // sub r2, r4, r5
        put(2, enc_r(10, 11, 9, FN_AND));       // and r9, r10, r11
        put(3, enc_r(17, 18, 16, FN_OR));       // or  r16, r17, r18
        put(4, enc_r(14, 0, 13, FN_ADD));       // add r13, r14, r0
        run(10);
        chk_idle("R3 before first retire", 3);
        chk_wb("R5 load", 4, 8, 32'd99);
        chk_wb("R4 sub", 5, 2, 32'hFFFF_FFFF);
        chk_wb("R4 and", 6, 9, 32'd110);
        chk_wb("R4 or", 7, 16, 32'd119);
        chk_wb("R10 add with r0", 8, 13, 32'd114);
        chk_idle("R3 drained in ninth cycle", 9);
    endtask

    // R6, R9: same-cycle bypass boundary, store then load
    task automatic t_bypass_store();
        new_prog();
        put(0, enc_r(1, 2, 3, FN_ADD));         // r3 = 203
        put(1, enc_r(2, 1, 4, FN_SUB));         // r4 = 1
        put(3, enc_r(3, 4, 5, FN_ADD));         // r3 bypassed, r4 still old
        put(4, enc_i(OPC_STORE, 0, 3, 8));      // sw r3, 8(r0)
        put(5, enc_i(OPC_LOAD, 0, 6, 8));       // lw r6, 8(r0)
        put(6, enc_i(OPC_LOAD, 0, 7, 12));      // lw r7, 12(r0)
        run(11);
        chk_wb("R4 add", 4, 3, 32'd203);
        chk_wb("R4 sub", 5, 4, 32'd1);
        chk_idle("R11 zero word", 6);
        chk_wb("R9 bypass new and old", 7, 5, 32'd307);
        chk_idle("R6 store no writeback", 8);
        chk_wb("R6 load after store", 9, 6, 32'd203);
        chk_wb("R5 untouched word", 10, 7, 32'd99);
    endtask

    // R7, R8: taken branch with three shadow instructions
    task automatic t_branch_taken();
        new_prog();
        put(0, enc_i(OPC_BEQ, 1, 1, 5));        // target 4 + 20 = 24
        put(1, enc_r(1, 1, 10, FN_ADD));
        put(2, enc_r(2, 2, 11, FN_ADD));
        put(3, enc_r(3, 3, 12, FN_ADD));
        put(4, enc_r(1, 0, 13, FN_ADD));        // skipped
        put(5, enc_r(1, 0, 14, FN_ADD));        // skipped
        put(6, enc_r(1, 2, 15, FN_OR));
        run(10);
        chk("R7 pc before redirect", pc_log[3], 32'd12);
        chk("R7 pc redirected", pc_log[4], 32'd24);
        chk("R7 pc after redirect", pc_log[5], 32'd28);
        chk_idle("R7 branch no writeback", 4);
        chk_wb("R8 shadow 1", 5, 10, 32'd202);
        chk_wb("R8 shadow 2", 6, 11, 32'd204);
        chk_wb("R8 shadow 3", 7, 12, 32'd206);
        chk_wb("R7 target instr", 8, 15, 32'd103);
    endtask

    // R7: branch not taken
    task automatic t_branch_not_taken();
        new_prog();
        put(0, enc_i(OPC_BEQ, 1, 2, 5));
        put(4, enc_r(1, 0, 13, FN_ADD));
        run(9);
        chk("R7 not taken pc", pc_log[4], 32'd16);
        chk_wb("R7 fall-through", 8, 13, 32'd101);
    endtask

    // R10: writes to register 0 dropped, also on the bypass path
    task automatic t_zero_reg();
        new_prog();
        put(0, enc_r(1, 2, 0, FN_ADD));         // add r0, r1, r2
        put(3, enc_r(0, 0, 9, FN_ADD));         // decodes while r0 write retires
        put(4, enc_r(0, 1, 8, FN_OR));
        run(9);
        chk_idle("R10 r0 write suppressed", 4);
        chk_wb("R10 r0 bypass blocked", 7, 9, 32'd0);
        chk_wb("R10 r0 still zero", 8, 8, 32'd101);
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_and_bubbles();
        t_sequence();
        t_bypass_store();
        t_branch_taken();
        t_branch_not_taken();
        t_zero_reg();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule